// File: doc/BRIEF.md
# BCD Calendar Counter Chain

This block keeps wall-clock time and the calendar date in packed BCD. A qualified one-second enable advances a chain of seconds, minutes, 24-hour hours, weekday, day of month, month and two-digit year. A century flag toggles at the year rollover when its enable bit is set. The calendar knows the length of each month, and it inserts February 29th in years whose two-digit value is a multiple of four.

A host reaches seven byte-wide registers through a plain parallel port. Writes go straight into the live counters. Reads come from a shadow image of all seven bytes that is refreshed in one step each cycle. While the host holds a read of a clock address, the shadow stays frozen so the host sees a consistent time. The live counters keep counting during the freeze, so no seconds are lost.

The seconds byte carries a halt bit that stops timekeeping. The minutes byte carries a sticky oscillator-fault flag. That flag is set at reset, whenever the oscillator is reported stopped, and while the halt bit is set. A host write of 0 clears it only once the oscillator has run for four counted seconds. Every host write to a clock address raises a strobe that clears the external sub-second divider.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the registers read, at addresses 0 to 6: 00h, 80h, 00h, 01h, 01h, 01h, 00h (halt bit 0, fault flag 1, 00:00:00, weekday 1, 01-01-00, century enable and century bit 0).
- R2: Each accepted tick adds one second. Seconds (address 0, bits 6..0) and minutes (address 1, bits 6..0) wrap from 59 to 00 and carry. Hours (address 2, bits 5..0) wrap from 23 to 00 and carry to the date. All digits are packed BCD.
- R3: At the midnight carry the weekday (address 3, bits 2..0) advances by one, and 7 wraps to 1.
- R4: The day of month (address 4, bits 5..0) wraps to 01 and carries to the month after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months. In month 02 it wraps after 29 when the year value is a multiple of four (00 counts), and after 28 otherwise.
- R5: The month (address 5, bits 4..0) wraps from 12 to 01 and carries to the year. The year (address 6) counts 00 to 99 and then wraps to 00.
- R6: Address 2 bit 7 is the century enable and bit 6 is the century bit. When the year wraps from 99 to 00, the century bit inverts if the enable is 1 and holds if the enable is 0.
- R7: While the halt bit (address 0, bit 7) is 1, ticks have no effect. Ticks also have no effect while `osc_ok` is low. After the halt bit is cleared, the next tick advances the time.
- R8: The fault flag (address 1, bit 7) is set one cycle after `osc_ok` is low or the halt bit is 1. A host write of 0 to that bit clears it only when at least 4 ticks have been counted since the oscillator last stopped or was halted; otherwise the flag stays 1. A write of 1 to that bit has no effect on the flag.
- R9: `div_clr` is high in the same cycle as a host write to addresses 0 to 6, and low otherwise, including for writes to address 7.
- R10: Reads return the shadow image. The image reloads from the live counters every cycle, except while `rd_busy` is high with `rd_addr` in 0 to 6. After the freeze ends, the image shows the time, including ticks that arrived during the freeze.
- R11: Host-written values are stored without range checks, and unused bits read 0. A write that lands in the same cycle as a tick wins, and that tick is dropped.
- R12: Address 7 reads 00h, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| osc_ok | input | 1 | High while the oscillator is running |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host write address |
| wr_data | input | 8 | Host write data |
| rd_busy | input | 1 | Host read in progress (freezes the image for addresses 0-6) |
| rd_addr | input | 3 | Host read address |
| rd_data | output | 8 | Shadow image byte at `rd_addr` (combinational) |
| div_clr | output | 1 | Clear request for the external sub-second divider |

## Verification
`div_clr` is combinational, so the bench drives a write at a falling edge and checks the strobe in that same cycle. A write or tick reaches the live counters at the next rising edge and the readable image at the rising edge after that. A halt write makes the fault flag visible one edge later still. Each read task therefore moves its address at a falling edge that follows at least two rising edges after the stimulus, and samples shortly afterwards. The freeze tests hold `rd_busy` across several tick edges before the release, so a stale image and a lost tick each show up as a distinct wrong value.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int NREG   = 7;
  localparam int ADDR_W = $clog2(NREG + 1);

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [5:0] hr;
    logic [2:0] dow;
    logic [5:0] date;
    logic [4:0] mon;
    logic [7:0] yr;
    logic       ceb;
    logic       cb;
  } cal_t;

  localparam cal_t CAL_RST = '{sec: 7'h00, min: 7'h00, hr: 6'h00, dow: 3'd1,
                               date: 6'h01, mon: 5'h01, yr: 8'h00,
                               ceb: 1'b0, cb: 1'b0};

  // byte 6 (year) down to byte 0 (seconds)
  localparam logic [8*NREG-1:0] IMG_RST = 56'h00_01_01_01_00_80_00;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // two-digit BCD year divisible by four
  function automatic logic is_leap(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [5:0] last_day(input logic [4:0] m, input logic [7:0] y);
    case (m)
      5'h02:                      return is_leap(y) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_cal_chain.sv
module rtc_cal_chain
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              osc_ok,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output cal_t              cal,
  output logic              halt
);
  cal_t       nxt;
  logic       step_ok;
  logic [7:0] t_sec, t_min, t_hr, t_date, t_mon, t_yr;

  assign step_ok = tick && osc_ok && !halt;

  always_comb begin
    t_sec  = bcd_inc({1'b0, cal.sec});
    t_min  = bcd_inc({1'b0, cal.min});
    t_hr   = bcd_inc({2'b0, cal.hr});
    t_date = bcd_inc({2'b0, cal.date});
    t_mon  = bcd_inc({3'b0, cal.mon});
    t_yr   = bcd_inc(cal.yr);
    nxt    = cal;
    if (cal.sec != 7'h59) nxt.sec = t_sec[6:0];
    else begin
      nxt.sec = 7'h00;
      if (cal.min != 7'h59) nxt.min = t_min[6:0];
      else begin
        nxt.min = 7'h00;
        if (cal.hr != 6'h23) nxt.hr = t_hr[5:0];
        else begin
          nxt.hr  = 6'h00;
          nxt.dow = (cal.dow >= 3'd7) ? 3'd1 : cal.dow + 3'd1;
          if (cal.date != last_day(cal.mon, cal.yr)) nxt.date = t_date[5:0];
          else begin
            nxt.date = 6'h01;
            if (cal.mon != 5'h12) nxt.mon = t_mon[4:0];
            else begin
              nxt.mon = 5'h01;
              if (cal.yr != 8'h99) nxt.yr = t_yr;
              else begin
                nxt.yr = 8'h00;
                if (cal.ceb) nxt.cb = ~cal.cb;
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal  <= CAL_RST;
      halt <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: begin halt <= wr_data[7]; cal.sec <= wr_data[6:0]; end
        3'd1: cal.min  <= wr_data[6:0];
        3'd2: begin cal.ceb <= wr_data[7]; cal.cb <= wr_data[6]; cal.hr <= wr_data[5:0]; end
        3'd3: cal.dow  <= wr_data[2:0];
        3'd4: cal.date <= wr_data[5:0];
        3'd5: cal.mon  <= wr_data[4:0];
        3'd6: cal.yr   <= wr_data;
        default: ;
      endcase
    end else if (step_ok) begin
      cal <= nxt;
    end
  end

  p_halt_freezes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !wr_en) |=> $stable(cal));
  p_dow_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ok && !wr_en && cal.sec == 7'h59 && cal.min == 7'h59 &&
     cal.hr == 6'h23 && cal.dow == 3'd7) |=> (cal.dow == 3'd1));
  p_cb_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal.ceb && !wr_en) |=> $stable(cal.cb));
endmodule

// File: rtl/rtc_osc_guard.sv
module rtc_osc_guard #(
  parameter int RUN_SECS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic osc_ok,
  input  logic halt,
  input  logic clr_req,
  output logic fault
);
  localparam int CW = $clog2(RUN_SECS + 1);
  localparam logic [CW-1:0] FULL = CW'(RUN_SECS);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      fault   <= 1'b1;
    end else if (!osc_ok || halt) begin
      run_cnt <= '0;
      fault   <= 1'b1;
    end else begin
      if (tick && run_cnt != FULL) run_cnt <= run_cnt + 1'b1;
      if (clr_req && run_cnt == FULL) fault <= 1'b0;
    end
  end

  p_fault_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_ok || halt) |=> fault);
  p_fault_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault) |-> ($past(clr_req) && $past(osc_ok)));
endmodule

// File: rtl/rtc_user_copy.sv
module rtc_user_copy
  import rtc_cal_pkg::*;
#(
  parameter int                NB      = NREG,
  parameter logic [8*NB-1:0]   RST_IMG = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            freeze,
  input  logic [8*NB-1:0] live,
  output logic [8*NB-1:0] image
);
  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       image[8*b +: 8] <= RST_IMG[8*b +: 8];
      else if (!freeze) image[8*b +: 8] <= live[8*b +: 8];
    end
  end

  p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(image));
  p_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !freeze |=> (image == $past(live)));
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int RUN_SECS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              osc_ok,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_busy,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              div_clr
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NREG - 1);

  cal_t              cal;
  logic              halt, fault, clr_req, freeze;
  logic [8*NREG-1:0] live, image;
  logic [7:0]        img_b [2**ADDR_W];

  assign div_clr = wr_en && (wr_addr <= LAST);
  assign clr_req = wr_en && (wr_addr == ADDR_W'(1)) && !wr_data[7];
  assign freeze  = rd_busy && (rd_addr <= LAST);

  rtc_cal_chain u_chain (
    .clk(clk), .rst_n(rst_n), .tick(sec_tick), .osc_ok(osc_ok),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cal(cal), .halt(halt)
  );

  rtc_osc_guard #(.RUN_SECS(RUN_SECS)) u_guard (
    .clk(clk), .rst_n(rst_n), .tick(sec_tick), .osc_ok(osc_ok),
    .halt(halt), .clr_req(clr_req), .fault(fault)
  );

  assign live = {cal.yr, 3'b0, cal.mon, 2'b0, cal.date, 5'b0, cal.dow,
                 cal.ceb, cal.cb, cal.hr, fault, cal.min, halt, cal.sec};

  rtc_user_copy #(.NB(NREG), .RST_IMG(IMG_RST)) u_copy (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .live(live), .image(image)
  );

  for (genvar a = 0; a < 2**ADDR_W; a++) begin : g_rd
    if (a < NREG) begin : g_reg
      assign img_b[a] = image[8*a +: 8];
    end else begin : g_void
      assign img_b[a] = 8'h00;
    end
  end

  assign rd_data = img_b[rd_addr];

  p_divclr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    div_clr |-> wr_en);
  p_void_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == ADDR_W'(7)) |-> (rd_data == 8'h00));
endmodule

// File: tb/tb_rtc_calendar.sv
module tb_rtc_calendar;
  localparam int CLK_P = 10;
  localparam int NV    = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sec_tick = 1'b0, osc_ok = 1'b1, wr_en = 1'b0, rd_busy = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic div_clr;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  rtc_calendar dut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .osc_ok(osc_ok),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_busy(rd_busy), .rd_addr(rd_addr), .rd_data(rd_data), .div_clr(div_clr)
  );

  // {req, set bytes sec..yr, expected bytes sec..yr} after one tick
  localparam logic [119:0] VEC [NV] = '{
    {8'd2, 56'h56341203150624, 56'h57341203150624},  // R2 plain second
    {8'd2, 56'h59591002100321, 56'h00001102100321},  // R2 hour carry
    {8'd3, 56'h59592307300423, 56'h00000001010523},  // R3 weekday 7->1, 30-day month
    {8'd4, 56'h59592304280223, 56'h00000005010323},  // R4 Feb 28 non-leap
    {8'd4, 56'h59592304280224, 56'h00000005290224},  // R4 Feb 28 leap
    {8'd4, 56'h59592305290224, 56'h00000006010324},  // R4 Feb 29 leap
    {8'd4, 56'h59592301280200, 56'h00000002290200},  // R4 year 00 leap
    {8'd4, 56'h59592301280296, 56'h00000002290296},  // R4 year 96 leap
    {8'd4, 56'h59592301280298, 56'h00000002010398},  // R4 year 98 not leap
    {8'd4, 56'h59592306300125, 56'h00000007310125},  // R4 31-day month
    {8'd4, 56'h59592307310125, 56'h00000001010225},  // R4 Jan 31
    {8'd4, 56'h59592302300925, 56'h00000003011025},  // R4 Sep 30
    {8'd5, 56'h59592302301125, 56'h00000003011225},  // R5 Nov 30
    {8'd5, 56'h59592303311226, 56'h00000004010127},  // R5 year carry
    {8'd6, 56'h5959A303311299, 56'h0000C004010100},  // R6 cb 0->1
    {8'd6, 56'h5959E303311299, 56'h00008004010100},  // R6 cb 1->0
    {8'd6, 56'h59596303311299, 56'h00004004010100},  // R6 cb holds
    {8'd2, 56'h59590903150624, 56'h00001003150624},  // R2 hour tens
    {8'd2, 56'h59090003150624, 56'h00100003150624},  // R2 minute tens
    {8'd4, 56'h59592305310319, 56'h00000006010419}   // R4 Mar 31
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h exp %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); rd_addr = a; #1 v = rd_data;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got timeout exp completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] rst_exp [8] = '{8'h00, 8'h80, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset image, R12 address 7 reads zero
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v); chk(a == 7 ? "R12" : "R1", v, rst_exp[a]);
    end

    // R8: early clear refused, then honoured after 4 ticks
    tick(2);
    wr(3'd1, 8'h00);
    rd(3'd1, v); chk("R8", v, 8'h80);
    rd(3'd0, v); chk("R2", v, 8'h02);
    tick(2);
    wr(3'd1, 8'h80);
    rd(3'd1, v); chk("R8", v, 8'h80);
    wr(3'd1, 8'h00);
    rd(3'd1, v); chk("R8", v, 8'h00);

    // table walk: R2 R3 R4 R5 R6
    for (int e = 0; e < NV; e++) begin
      for (int b = 0; b < 7; b++) wr(3'(b), VEC[e][111-8*b -: 8]);
      tick(1);
      for (int b = 0; b < 7; b++) begin
        rd(3'(b), v);
        chk($sformatf("R%0d entry %0d byte %0d", VEC[e][119:112], e, b), v, VEC[e][55-8*b -: 8]);
      end
    end

    // R9 / R12: write to address 7
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'd7; wr_data = 8'hFF;
    #1 chk("R9", {7'b0, div_clr}, 8'h01 ^ 8'h01);
    @(negedge clk); wr_en = 1'b0;
    rd(3'd7, v); chk("R12", v, 8'h00);
    rd(3'd3, v); chk("R12", v, 8'h06);
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'd3; wr_data = 8'h04;
    #1 chk("R9", {7'b0, div_clr}, 8'h01);
    @(negedge clk); wr_en = 1'b0;
    #1 chk("R9", {7'b0, div_clr}, 8'h00);
    rd(3'd3, v); chk("R9", v, 8'h04);

    // R7 halt stops time and raises the fault flag
    wr(3'd0, 8'h90);
    tick(3);
    rd(3'd0, v); chk("R7", v, 8'h90);
    rd(3'd1, v); chk("R8", v & 8'h80, 8'h80);
    wr(3'd0, 8'h10);
    tick(1);
    rd(3'd0, v); chk("R7", v, 8'h11);
    wr(3'd1, 8'h00);
    rd(3'd1, v); chk("R8", v, 8'h80);
    tick(4);
    wr(3'd1, 8'h00);
    rd(3'd1, v); chk("R8", v, 8'h00);
    @(negedge clk); osc_ok = 1'b0;
    tick(1);
    @(negedge clk); osc_ok = 1'b1;
    rd(3'd0, v); chk("R7", v, 8'h15);
    rd(3'd1, v); chk("R8", v, 8'h80);

    // R10 freeze during read of a clock address
    @(negedge clk); rd_busy = 1'b1; rd_addr = 3'd0;
    tick(2);
    rd(3'd0, v); chk("R10", v, 8'h15);
    @(negedge clk); rd_busy = 1'b0;
    rd(3'd0, v); chk("R10", v, 8'h17);
    @(negedge clk); rd_busy = 1'b1; rd_addr = 3'd7;
    tick(1);
    rd(3'd0, v); chk("R10", v, 8'h18);
    @(negedge clk); rd_busy = 1'b0;

    // R11 write beats a same-cycle tick; no range checks; unused bits zero
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h30; sec_tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; sec_tick = 1'b0;
    rd(3'd0, v); chk("R11", v, 8'h30);
    wr(3'd0, 8'h7F); rd(3'd0, v); chk("R11", v, 8'h7F);
    wr(3'd4, 8'hFF); rd(3'd4, v); chk("R11", v, 8'h3F);
    wr(3'd5, 8'hFF); rd(3'd5, v); chk("R11", v, 8'h1F);
    wr(3'd3, 8'hFF); rd(3'd3, v); chk("R11", v, 8'h07);

    done = 1'b1;
    finish_run();
  end
endmodule